// File: doc/BRIEF.md
# Two-Bank Interrupt Controller Core

This block gathers forty level-sensitive interrupt lines into two 32-bit banks. Lines 0 to 31 occupy bank 0, and lines 32 to 39 occupy the low eight bits of bank 1. Each line passes through a two-flop synchronizer. The synchronized level is the line's pending bit. Each source has an enable bit and a class bit, and the class bit steers the source to one of two outputs: a fast interrupt or a normal interrupt. A third output asks the processor to wake while it is halted. That wake path can be told to respond to every pending source, enabled or not.

Software uses a word-wide register port. Through it, software writes the enable, class, idle-control and forty priority registers. It reads the masked fast and normal views of each bank, the raw pending bits and a highest-pending word. A separate resolver computes that word and feeds it to this block. The block also exports the active source vectors and the stored priority slots so that the resolver can do its work.

Top module: `intc_dual_bank`

## Requirements
- R1: Source n with n below 32 appears in bank 0 at bit n. Source n from 32 to 39 appears in bank 1 at bit n-32. Bits 8 to 31 of bank 1 pending always read 0.
- R2: Pending bits follow the source levels with no latching. A level change becomes visible in the raw pending registers on the second rising clock edge after it is applied, and a falling input clears the bit in the same way.
- R3: The fast output goes high one clock after any source is pending, enabled and has its class bit at 1, in either bank.
- R4: The normal output goes high one clock after any source is pending, enabled and has its class bit at 0, in either bank. Both outputs can be high together.
- R5: While the halt input is high, the wake output goes high one clock after pending AND (enable OR idle-mask) is nonzero in either bank. Wake is low one clock after the halt input is low.
- R6: A write to idle control (0x14) with bit 0 = 1 sets the idle-mask to all zeros, and with bit 0 = 0 sets it to all ones. A read returns 1 exactly when the idle-mask is all zeros.
- R7: The bank 0 map is: 0x00 normal view (pending & enable & ~class), 0x04 enable, 0x08 class, 0x0C fast view (pending & enable & class), 0x10 raw pending, 0x14 idle control, and 0x18 the highest-pending word.
- R8: The bank 1 registers keep the bank 0 order at 0x9C (normal view), 0xA0 (enable), 0xA4 (class), 0xA8 (fast view) and 0xAC (raw pending).
- R9: Priority slot k sits at 0x1C+4k for k from 0 to 31, and at 0xB0+4(k-32) for k from 32 to 39. A write keeps only bit 31 and bits 5:0, so a read returns the written value ANDed with 0x8000003F.
- R10: After reset, the following are all zero: enable, class and pending in both banks, every priority slot, and all three outputs. The idle-mask is all zeros, so idle control reads 1.
- R11: The views, raw pending and highest-pending word are read-only. Writes to them, and to unmapped or misaligned offsets, change no state. Unmapped offsets read 0.
- R12: A read of offset 0x18 returns the highest-pending input word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Asynchronous level interrupt sources |
| halted_i | input | 1 | Processor is halted |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| hp_word_i | input | 32 | Highest-pending word from the resolver |
| fast_irq_o | output | 1 | Fast interrupt request, registered |
| norm_irq_o | output | 1 | Normal interrupt request, registered |
| wake_o | output | 1 | Wake request while halted, registered |
| act_fast_o | output | NSRC | Per-source pending & enable & class |
| act_norm_o | output | NSRC | Per-source pending & enable & ~class |
| prio_o | output | NSRC*7 | Priority slots, {valid, index[5:0]} per slot |

## Verification
The bench drives sources 3 and 35 together. This catches a design that puts the upper sources at the wrong bank or bit. It times pending and the outputs to the exact edge, so a synchronizer that is one stage short or long fails.

Sources with no enable must still wake the core when the idle-mask is all ones, and must stop doing so once idle control is written with 1. A design that ignores the idle-mask in the wake term, or inverts bit 0, fails here.

The priority slots are written at both ends of each address range with all-ones and mixed patterns. This catches slots placed at the wrong offsets and bits that should have been masked off. Writes go to the read-only views, to one misaligned offset near idle control and to one offset past the map. Any decode that ignores the low address bits, or that stores through a view, then shows up as changed state.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int BANK_W   = 32;
   localparam int IDX_W    = 6;
   localparam int SLOT_W   = IDX_W + 1;
   localparam int MAX_SRC  = 40;

   // offsets inside one bank group (same order in both banks)
   localparam logic [7:0] GRP_NRM  = 8'h00;
   localparam logic [7:0] GRP_ENA  = 8'h04;
   localparam logic [7:0] GRP_CLS  = 8'h08;
   localparam logic [7:0] GRP_FST  = 8'h0C;
   localparam logic [7:0] GRP_RAW  = 8'h10;

   localparam logic [7:0] BASE_B0  = 8'h00;
   localparam logic [7:0] BASE_B1  = 8'h9C;
   localparam logic [7:0] ADR_IDLE = 8'h14;
   localparam logic [7:0] ADR_TOP  = 8'h18;
   localparam logic [7:0] SLOT_LO  = 8'h1C;
   localparam logic [7:0] SLOT_HI  = 8'hB0;

   typedef struct packed {
      logic             valid;
      logic [IDX_W-1:0] idx;
   } slot_t;

   function automatic logic [7:0] bank_adr(input int b, input logic [7:0] ofs);
      return ((b == 0) ? BASE_B0 : BASE_B1) + ofs;
   endfunction

   function automatic logic [7:0] slot_adr(input int k);
      if (k < BANK_W) return SLOT_LO + 8'(4 * k);
      else            return SLOT_HI + 8'(4 * (k - BANK_W));
   endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
   parameter int W      = 40,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("intc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int NSRC   = 40,
   parameter int NBANK  = 2,
   parameter int ADDR_W = 8,
   localparam int VW    = NBANK * BANK_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic                   wr_i,
   input  logic [31:0]            wdata_i,
   output logic [31:0]            rdata_o,
   input  logic [VW-1:0]          pend_i,
   input  logic [31:0]            hp_word_i,
   output logic [VW-1:0]          ena_o,
   output logic [VW-1:0]          cls_o,
   output logic                   idle_all_o,
   output logic [NSRC*SLOT_W-1:0] prio_o
);

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] c);
      return a == ADDR_W'(c);
   endfunction

   // per-bank enable and class storage
   genvar b;
   generate
      for (b = 0; b < NBANK; b++) begin : g_bank
         logic [BANK_W-1:0] ena_q, cls_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ena_q <= '0;
               cls_q <= '0;
            end else if (wr_i) begin
               if (hit(addr_i, bank_adr(b, GRP_ENA))) ena_q <= wdata_i;
               if (hit(addr_i, bank_adr(b, GRP_CLS))) cls_q <= wdata_i;
            end
         end
         assign ena_o[b*BANK_W +: BANK_W] = ena_q;
         assign cls_o[b*BANK_W +: BANK_W] = cls_q;
      end
   endgenerate

   // idle-mask: 1 means every pending source may wake the core
   logic idle_all_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            idle_all_q <= 1'b0;
      else if (wr_i && hit(addr_i, ADR_IDLE)) idle_all_q <= ~wdata_i[0];
   end
   assign idle_all_o = idle_all_q;

   // priority slots
   genvar k;
   generate
      for (k = 0; k < NSRC; k++) begin : g_slot
         slot_t slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= '0;
            end else if (wr_i && hit(addr_i, slot_adr(k))) begin
               slot_q.valid <= wdata_i[31];
               slot_q.idx   <= wdata_i[IDX_W-1:0];
            end
         end
         assign prio_o[k*SLOT_W +: SLOT_W] = slot_q;
      end
   endgenerate

   // read decode
   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NBANK; i++) begin
         logic [BANK_W-1:0] p, e, c;
         p = pend_i[i*BANK_W +: BANK_W];
         e = ena_o[i*BANK_W +: BANK_W];
         c = cls_o[i*BANK_W +: BANK_W];
         if (hit(addr_i, bank_adr(i, GRP_NRM))) rdata_o = p & e & ~c;
         if (hit(addr_i, bank_adr(i, GRP_ENA))) rdata_o = e;
         if (hit(addr_i, bank_adr(i, GRP_CLS))) rdata_o = c;
         if (hit(addr_i, bank_adr(i, GRP_FST))) rdata_o = p & e & c;
         if (hit(addr_i, bank_adr(i, GRP_RAW))) rdata_o = p;
      end
      if (hit(addr_i, ADR_IDLE)) rdata_o = {31'b0, ~idle_all_q};
      if (hit(addr_i, ADR_TOP))  rdata_o = hp_word_i;
      for (int j = 0; j < NSRC; j++) begin
         if (hit(addr_i, slot_adr(j)))
            rdata_o = {prio_o[j*SLOT_W + IDX_W], {(31-IDX_W){1'b0}},
                       prio_o[j*SLOT_W +: IDX_W]};
      end
   end

   // R6: idle control write sets the mask on the next cycle
   a_r6_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && hit(addr_i, ADR_IDLE)) |=> (idle_all_o == !$past(wdata_i[0])));

   // R11: a write to the raw pending offset leaves enable untouched
   a_r11_raw_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && hit(addr_i, bank_adr(0, GRP_RAW))) |=> $stable(ena_o));

endmodule

// File: rtl/intc_outgen.sv
module intc_outgen
   import intc_pkg::*;
#(
   parameter int NBANK = 2,
   localparam int VW   = NBANK * BANK_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] pend_i,
   input  logic [VW-1:0] ena_i,
   input  logic [VW-1:0] cls_i,
   input  logic          idle_all_i,
   input  logic          halted_i,
   output logic          fast_o,
   output logic          norm_o,
   output logic          wake_o
);

   logic [NBANK-1:0] fast_b, norm_b, wake_b;

   genvar b;
   generate
      for (b = 0; b < NBANK; b++) begin : g_bank
         logic [BANK_W-1:0] p, e, c;
         assign p = pend_i[b*BANK_W +: BANK_W];
         assign e = ena_i[b*BANK_W +: BANK_W];
         assign c = cls_i[b*BANK_W +: BANK_W];
         assign fast_b[b] = |(p & e & c);
         assign norm_b[b] = |(p & e & ~c);
         assign wake_b[b] = |(p & (e | {BANK_W{idle_all_i}}));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_o <= 1'b0;
         norm_o <= 1'b0;
         wake_o <= 1'b0;
      end else begin
         fast_o <= |fast_b;
         norm_o <= |norm_b;
         wake_o <= halted_i & (|wake_b);
      end
   end

   // R5: no wake request while the processor runs
   a_r5_wake_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
      !halted_i |=> !wake_o);

   // R3: fast request needs at least one class bit set
   a_r3_fast_needs_class: assert property (@(posedge clk) disable iff (!rst_n)
      fast_o |-> $past(|cls_i));

   // R4: normal request needs a pending source
   a_r4_norm_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      norm_o |-> $past(|pend_i));

endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
   import intc_pkg::*;
#(
   parameter int NSRC        = 40,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NBANK      = (NSRC + BANK_W - 1) / BANK_W,
   localparam int VW         = NBANK * BANK_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC-1:0]        src_i,
   input  logic                   halted_i,
   input  logic [ADDR_W-1:0]      reg_addr_i,
   input  logic                   reg_wr_i,
   input  logic [31:0]            reg_wdata_i,
   output logic [31:0]            reg_rdata_o,
   input  logic [31:0]            hp_word_i,
   output logic                   fast_irq_o,
   output logic                   norm_irq_o,
   output logic                   wake_o,
   output logic [NSRC-1:0]        act_fast_o,
   output logic [NSRC-1:0]        act_norm_o,
   output logic [NSRC*SLOT_W-1:0] prio_o
);

   generate
      if (NSRC <= BANK_W || NSRC > MAX_SRC) begin : g_bad_nsrc
         $error("intc_dual_bank: NSRC must lie in 33..40 for the fixed map");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("intc_dual_bank: ADDR_W must be at least 8");
      end
   endgenerate

   logic [NSRC-1:0] pend_raw;
   logic [VW-1:0]   pend_v, ena_v, cls_v;
   logic            idle_all;

   intc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (pend_raw)
   );

   assign pend_v = {{(VW-NSRC){1'b0}}, pend_raw};

   intc_regs #(.NSRC(NSRC), .NBANK(NBANK), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (reg_addr_i),
      .wr_i       (reg_wr_i),
      .wdata_i    (reg_wdata_i),
      .rdata_o    (reg_rdata_o),
      .pend_i     (pend_v),
      .hp_word_i  (hp_word_i),
      .ena_o      (ena_v),
      .cls_o      (cls_v),
      .idle_all_o (idle_all),
      .prio_o     (prio_o)
   );

   intc_outgen #(.NBANK(NBANK)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_i     (pend_v),
      .ena_i      (ena_v),
      .cls_i      (cls_v),
      .idle_all_i (idle_all),
      .halted_i   (halted_i),
      .fast_o     (fast_irq_o),
      .norm_o     (norm_irq_o),
      .wake_o     (wake_o)
   );

   assign act_fast_o = pend_raw & ena_v[NSRC-1:0] &  cls_v[NSRC-1:0];
   assign act_norm_o = pend_raw & ena_v[NSRC-1:0] & ~cls_v[NSRC-1:0];

   // cycles since reset, saturating, for the pending-latency check
   logic [1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   generate
      if (SYNC_STAGES == 2) begin : g_lat_chk
         // R2: pending equals the source level two edges earlier
         a_r2_pend_tracks: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q >= 2'd2) |-> (pend_raw == $past(src_i, 2)));
      end
   endgenerate

   // R3, R4: with nothing enabled neither request can rise
   a_r3_r4_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_v == '0) |=> (!fast_irq_o && !norm_irq_o));

endmodule

// File: tb/sim_intc_dual_bank.sv
`timescale 1ns/1ps
module sim_intc_dual_bank;

   localparam int NSRC = 40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   src = '0;
   logic              halted = 1'b0;
   logic [7:0]        addr = '0;
   logic              wr = 1'b0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic [31:0]       hp_word = '0;
   logic              fast_irq, norm_irq, wake;
   logic [NSRC-1:0]   act_fast, act_norm;
   logic [NSRC*7-1:0] prio;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   intc_dual_bank #(.NSRC(NSRC), .ADDR_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src), .halted_i(halted),
      .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .hp_word_i(hp_word),
      .fast_irq_o(fast_irq), .norm_irq_o(norm_irq), .wake_o(wake),
      .act_fast_o(act_fast), .act_norm_o(act_norm), .prio_o(prio)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd_reg(8'h04, v); chk("R10 enable0", v, 0);
      rd_reg(8'hA0, v); chk("R10 enable1", v, 0);
      rd_reg(8'h08, v); chk("R10 class0", v, 0);
      rd_reg(8'hA4, v); chk("R10 class1", v, 0);
      rd_reg(8'h10, v); chk("R10 raw0", v, 0);
      rd_reg(8'hAC, v); chk("R10 raw1", v, 0);
      rd_reg(8'h14, v); chk("R10 R6 idle reads 1", v, 1);
      rd_reg(8'h30, v); chk("R10 slot5", v, 0);
      chk("R10 outputs low", {29'b0, fast_irq, norm_irq, wake}, 0);
   endtask

   task automatic t_bank_map;
      logic [31:0] v;
      addr = 8'h10;
      src[3] = 1'b1; src[35] = 1'b1;
      tick(1); chk("R2 raw0 not yet after one edge", rdata, 0);
      tick(1); chk("R2 R1 raw0 bit3 after two edges", rdata, 32'h8);
      rd_reg(8'hAC, v); chk("R1 raw1 bit3 from source 35", v, 32'h8);
      src = '0;
      tick(2);
      rd_reg(8'h10, v); chk("R2 raw0 clears with input", v, 0);
      rd_reg(8'hAC, v); chk("R2 raw1 clears with input", v, 0);
   endtask

   task automatic t_fast_normal;
      logic [31:0] v;
      wr_reg(8'h04, 32'h8);
      wr_reg(8'hA0, 32'h8);
      wr_reg(8'hA4, 32'h8);
      src[3] = 1'b1; src[35] = 1'b1;
      tick(3);
      chk("R3 fast high", {31'b0, fast_irq}, 1);
      chk("R4 normal high", {31'b0, norm_irq}, 1);
      rd_reg(8'h00, v); chk("R7 normal view bank0", v, 32'h8);
      rd_reg(8'h0C, v); chk("R7 fast view bank0", v, 0);
      rd_reg(8'h9C, v); chk("R8 normal view bank1", v, 0);
      rd_reg(8'hA8, v); chk("R8 fast view bank1", v, 32'h8);
      wr_reg(8'h04, 32'h0);
      tick(1);
      chk("R4 normal drops when disabled", {31'b0, norm_irq}, 0);
      chk("R3 fast stays", {31'b0, fast_irq}, 1);
      src = '0;
      tick(3);
      chk("R3 fast drops with source", {31'b0, fast_irq}, 0);
      wr_reg(8'hA0, 32'h0);
      wr_reg(8'hA4, 32'h0);
   endtask

   task automatic t_wake;
      logic [31:0] v;
      wr_reg(8'h14, 32'h0);
      rd_reg(8'h14, v); chk("R6 idle reads 0 when mask all ones", v, 0);
      halted = 1'b1;
      src[10] = 1'b1;
      tick(3);
      chk("R5 wake on unenabled source", {31'b0, wake}, 1);
      chk("R5 no normal without enable", {30'b0, fast_irq, norm_irq}, 0);
      halted = 1'b0;
      tick(1);
      chk("R5 wake low when running", {31'b0, wake}, 0);
      halted = 1'b1;
      tick(1);
      chk("R5 wake back when halted", {31'b0, wake}, 1);
      wr_reg(8'h14, 32'h1);
      tick(1);
      chk("R6 wake off with zero idle mask", {31'b0, wake}, 0);
      rd_reg(8'h14, v); chk("R6 idle reads 1", v, 1);
      wr_reg(8'h04, 32'h400);
      tick(1);
      chk("R5 wake on enabled source", {31'b0, wake}, 1);
      chk("R4 normal on enabled source", {31'b0, norm_irq}, 1);
      src = '0; halted = 1'b0;
      wr_reg(8'h04, 32'h0);
      tick(3);
   endtask

   task automatic t_prio;
      logic [31:0] v;
      wr_reg(8'h1C, 32'hFFFF_FFFF);
      wr_reg(8'h98, 32'h1234_5678);
      wr_reg(8'hB0, 32'h8000_0005);
      wr_reg(8'hCC, 32'h7FFF_FFC1);
      rd_reg(8'h1C, v); chk("R9 slot0 mask", v, 32'h8000_003F);
      rd_reg(8'h98, v); chk("R9 slot31 mask", v, 32'h0000_0038);
      rd_reg(8'hB0, v); chk("R9 slot32", v, 32'h8000_0005);
      rd_reg(8'hCC, v); chk("R9 slot39 mask", v, 32'h0000_0001);
      chk("R9 slot0 export", {25'b0, prio[6:0]}, 32'h7F);
   endtask

   task automatic t_readonly;
      logic [31:0] v;
      wr_reg(8'h04, 32'h5);
      src[0] = 1'b1;
      tick(2);
      wr_reg(8'h00, 32'hFFFF_FFFF);
      wr_reg(8'h0C, 32'hFFFF_FFFF);
      wr_reg(8'h10, 32'hFFFF_FFFF);
      wr_reg(8'h18, 32'hFFFF_FFFF);
      wr_reg(8'h9C, 32'hFFFF_FFFF);
      wr_reg(8'hA8, 32'hFFFF_FFFF);
      wr_reg(8'hAC, 32'hFFFF_FFFF);
      wr_reg(8'hD0, 32'hFFFF_FFFF);
      wr_reg(8'h15, 32'h0);
      wr_reg(8'h1D, 32'h0);
      wr_reg(8'h06, 32'hFFFF_FFFF);
      rd_reg(8'h04, v); chk("R11 enable0 kept", v, 32'h5);
      rd_reg(8'h08, v); chk("R11 class0 kept", v, 0);
      rd_reg(8'hA0, v); chk("R11 enable1 kept", v, 0);
      rd_reg(8'h10, v); chk("R11 raw0 follows input", v, 32'h1);
      rd_reg(8'h00, v); chk("R11 normal view", v, 32'h1);
      rd_reg(8'h14, v); chk("R11 idle kept after misaligned write", v, 1);
      rd_reg(8'h1C, v); chk("R11 slot0 kept", v, 32'h8000_003F);
      rd_reg(8'hD0, v); chk("R11 unmapped reads 0", v, 0);
      rd_reg(8'h15, v); chk("R11 misaligned reads 0", v, 0);
      src = '0;
      wr_reg(8'h04, 32'h0);
      tick(3);
   endtask

   task automatic t_hp;
      logic [31:0] v;
      hp_word = 32'h8005_0003;
      rd_reg(8'h18, v); chk("R12 highest word", v, 32'h8005_0003);
      hp_word = 32'h0000_803F;
      rd_reg(8'h18, v); chk("R12 highest word 2", v, 32'h0000_803F);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_bank_map();
      t_fast_normal();
      t_wake();
      t_prio();
      t_readonly();
      t_hp();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule